// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock Core

This block keeps wall-clock time for a chip that receives a slow time-base pulse. A single-cycle enable, `tick`, arrives at the sub-second rate (32768 per second by default). A sub-second counter turns these pulses into whole seconds. A BCD calendar then carries seconds into minutes, hours, day of month, month, a two-digit year for 2000 to 2099, and a weekday. Software reaches the calendar through a single-cycle register port with byte-wide writes and a combinational read. Time reads come from a shadow copy, which is refreshed only when software raises the capture control bit, so a read that spans several bytes always returns one consistent instant.

A run bit starts and stops the counters. Software clears it, loads the time bytes, and sets it again. A status bit reports that the counter has actually advanced since it was started. An optional signed crystal correction moves the sub-second counter once per hour, at the step from second 0 to second 1 within minute 00. This shortens or lengthens that one second. A six-field alarm comparator sets a sticky flag, which software clears by writing a one to it. An enable bit gates that flag onto the interrupt output.

Two state machines carry the control flow. The run tracker has the states RUN_STOPPED, RUN_STARTING and RUN_ACTIVE. It moves STOPPED→STARTING when the run bit is set, STARTING→ACTIVE on the first tick, and STARTING→STOPPED or ACTIVE→STOPPED when the run bit is cleared. The alarm tracker has the states ALM_IDLE, ALM_FLAGGED and ALM_SPENT. It moves IDLE→FLAGGED when the fields match. It moves FLAGGED→IDLE on a clear while the fields differ, and FLAGGED→SPENT on a clear while they still match. It moves SPENT→IDLE once the match ends.

Top module: `rtc_calendar_core`

## Requirements
- R1: Offsets 0x00..0x06 hold, in BCD, seconds, minutes, hours, day of month (01-31), month (01-12), year (00-99 meaning 2000-2099) and weekday (0-6), in that order. After reset the calendar reads 00:00:00, day 01, month 01, year 00, weekday 0, and offsets 0x10..0x13 read 0.
- R2: Control register 0x10 bit1 is the capture bit. A write that sets bit1 while its stored value is 0 copies the live calendar into the shadow registers that time reads return. A write with bit1=1 while it is already 1 leaves the shadow unchanged, and so does counting.
- R3: Control bit0 is the run bit. While it is 0, ticks do not advance the calendar. Any write to a time register also clears the sub-second count to 0.
- R4: Status register 0x11 bit0 is 0 while stopped. After the run bit is set, it reads 1 from the cycle after the first tick edge. It reads 0 again one cycle after the run bit is cleared.
- R5: With compensation idle, each second takes TICKS_PER_SEC counted ticks. Seconds carry into minutes at 59, minutes into hours at 59, hours into the day at 23, and year 99 wraps to 00.
- R6: Day of month wraps after the month's last day: 30 for months 04, 06, 09 and 11, 31 for the other months, and 28 for month 02, or 29 when the year is divisible by 4. The weekday steps at each day change and wraps from 6 to 0.
- R7: The 16-bit two's-complement compensation value is loaded as a low byte at 0x12 and then a high byte at 0x13. The high-byte write commits both bytes, and reads of 0x12/0x13 return the committed value only.
- R8: With control bit2 set, when seconds step from 0 to 1 while minutes read 00, the sub-second count is loaded with the compensation value C instead of 0. That second then lasts TICKS_PER_SEC−C ticks, with C clamped to at most TICKS_PER_SEC−1. With bit2 clear, or with minutes not 00, the value is not used.
- R9: Alarm registers 0x08..0x0D hold BCD seconds, minutes, hours, day, month and year. Status bit1 sets on the first cycle in which all six fields equal the calendar, and it stays set after the match ends.
- R10: Writing 0x11 with bit1=1 clears the alarm flag, and a write with bit1=0 leaves it. A flag cleared while the match persists does not set again until the match has ended and recurred.
- R11: `alarm_irq` is high exactly when the alarm flag is set and control bit3 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sub-second time-base enable, one cycle per tick |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| alarm_irq | output | 1 | Gated alarm interrupt |

## Verification
The calendar is exercised with random valid start dates, biased toward the last second of a day and toward the top of an hour, and advanced by random tick counts. A tick-level reference model predicts every field. Directed starts at Feb 28 in leap and common years, Apr 30, Dec 31 of year 99 and weekday 6 separate the month-length, leap and wrap rules from plain carrying. Compensation runs with positive, negative and oversized values, and at a minute other than 00. Together these show the counter loads the value, adds to or subtracts from the second, clamps it, and applies it only at the hourly point. Alarm runs compare the sticky flag, the write-zero no-op, the clear while the match persists, and the interrupt with the enable bit off and on.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] wday;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] mday;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] sec;
    } rtc_time_t;

    localparam rtc_time_t TIME_RST = '{wday: 8'h00, year: 8'h00, month: 8'h01,
                                       mday: 8'h01, hour: 8'h00, minute: 8'h00,
                                       sec: 8'h00};

    typedef enum logic [1:0] {
        RUN_STOPPED,
        RUN_STARTING,
        RUN_ACTIVE
    } run_state_t;

    typedef enum logic [1:0] {
        ALM_IDLE,
        ALM_FLAGGED,
        ALM_SPENT
    } alm_state_t;

    // Increment a two-digit BCD byte
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // Leap test for a BCD year 00..99 (divisible by four)
    function automatic logic bcd_leap(input logic [7:0] y);
        logic r;
        if (y[4]) r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else      r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return r;
    endfunction

    // Last day of a month, BCD
    function automatic logic [7:0] bcd_last_day(input logic [7:0] m, input logic [7:0] y);
        logic [7:0] r;
        case (m)
            8'h02:                      r = bcd_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_run_ctrl.sv
module rtc_run_ctrl
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    input  logic tick,
    output logic running
);
    run_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RUN_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_STOPPED:  if (run_req) state_d = RUN_STARTING;
            RUN_STARTING: begin
                if (!run_req)  state_d = RUN_STOPPED;
                else if (tick) state_d = RUN_ACTIVE;
            end
            RUN_ACTIVE:   if (!run_req) state_d = RUN_STOPPED;
            default:      state_d = RUN_STOPPED;
        endcase
    end

    always_comb begin
        running = (state_q == RUN_ACTIVE);
    end
endmodule

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        count_en,
    input  logic        tick,
    input  logic        clear,
    input  logic        comp_apply,
    input  logic [15:0] comp,
    output logic        sec_step
);
    localparam int NATIVE_W = $clog2(TICKS_PER_SEC) + 2;
    localparam int CW       = (NATIVE_W > 17) ? NATIVE_W : 17;
    localparam logic signed [CW-1:0] TERM = CW'(TICKS_PER_SEC - 1);
    localparam logic signed [CW-1:0] ONE  = CW'(1);

    logic signed [CW-1:0] cnt_q;
    logic signed [CW-1:0] comp_ext;
    logic signed [CW-1:0] load_val;

    assign comp_ext = {{(CW-16){comp[15]}}, comp};
    assign load_val = (comp_ext > TERM) ? TERM : comp_ext;
    assign sec_step = count_en && tick && (cnt_q >= TERM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (sec_step) begin
            cnt_q <= comp_apply ? load_val : '0;
        end else if (count_en && tick) begin
            cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/rtc_date_counter.sv
module rtc_date_counter
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sec_step,
    input  logic      wr_en,
    input  logic [2:0] wr_idx,
    input  logic [7:0] wr_data,
    output rtc_time_t now
);
    rtc_time_t cur_q, nxt;

    always_comb begin
        nxt = cur_q;
        if (sec_step) begin
            if (cur_q.sec >= 8'h59) begin
                nxt.sec = 8'h00;
                if (cur_q.minute >= 8'h59) begin
                    nxt.minute = 8'h00;
                    if (cur_q.hour >= 8'h23) begin
                        nxt.hour = 8'h00;
                        nxt.wday = (cur_q.wday >= 8'h06) ? 8'h00 : bcd_inc(cur_q.wday);
                        if (cur_q.mday >= bcd_last_day(cur_q.month, cur_q.year)) begin
                            nxt.mday = 8'h01;
                            if (cur_q.month >= 8'h12) begin
                                nxt.month = 8'h01;
                                nxt.year  = (cur_q.year >= 8'h99) ? 8'h00 : bcd_inc(cur_q.year);
                            end else begin
                                nxt.month = bcd_inc(cur_q.month);
                            end
                        end else begin
                            nxt.mday = bcd_inc(cur_q.mday);
                        end
                    end else begin
                        nxt.hour = bcd_inc(cur_q.hour);
                    end
                end else begin
                    nxt.minute = bcd_inc(cur_q.minute);
                end
            end else begin
                nxt.sec = bcd_inc(cur_q.sec);
            end
        end
        if (wr_en) begin
            case (wr_idx)
                3'd0:    nxt.sec    = wr_data;
                3'd1:    nxt.minute = wr_data;
                3'd2:    nxt.hour   = wr_data;
                3'd3:    nxt.mday   = wr_data;
                3'd4:    nxt.month  = wr_data;
                3'd5:    nxt.year   = wr_data;
                3'd6:    nxt.wday   = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= TIME_RST;
        else        cur_q <= nxt;
    end

    assign now = cur_q;
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [47:0] now_fields,
    input  logic [47:0] alarm_fields,
    input  logic        clr,
    output logic        flag
);
    alm_state_t state_q, state_d;
    logic match;

    assign match = (now_fields == alarm_fields);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ALM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_IDLE:    if (match) state_d = ALM_FLAGGED;
            ALM_FLAGGED: if (clr)   state_d = match ? ALM_SPENT : ALM_IDLE;
            ALM_SPENT:   if (!match) state_d = ALM_IDLE;
            default:     state_d = ALM_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == ALM_FLAGGED);
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int ADDR_W        = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              alarm_irq
);
    localparam int TIME_FIELDS = 7;
    localparam int ALM_FIELDS  = 6;
    localparam int BW          = 8;
    localparam logic [ADDR_W-1:0] A_ALARM   = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(17);
    localparam logic [ADDR_W-1:0] A_COMP_LO = ADDR_W'(18);
    localparam logic [ADDR_W-1:0] A_COMP_HI = ADDR_W'(19);

    // control state
    logic ctrl_run, ctl_cap, ctl_auto, ctl_ie;
    logic [7:0]  comp_stage;
    logic [15:0] comp_q;

    // datapath
    rtc_time_t now, shadow;
    logic [BW*TIME_FIELDS-1:0] now_flat, shadow_flat;
    logic [BW*ALM_FIELDS-1:0]  alm_flat;
    logic [BW-1:0]             alm_q [ALM_FIELDS];

    logic wr_time, capture, alarm_clr, sec_step, comp_apply, running, alarm_flag;

    assign now_flat    = now;
    assign shadow_flat = shadow;

    assign wr_time    = reg_wr && (reg_addr < ADDR_W'(TIME_FIELDS));
    assign capture    = reg_wr && (reg_addr == A_CTRL) && reg_wdata[1] && !ctl_cap;
    assign alarm_clr  = reg_wr && (reg_addr == A_STAT) && reg_wdata[1];
    assign comp_apply = ctl_auto && (now.sec == 8'h00) && (now.minute == 8'h00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_run <= 1'b0;
            ctl_cap  <= 1'b0;
            ctl_auto <= 1'b0;
            ctl_ie   <= 1'b0;
        end else if (reg_wr && reg_addr == A_CTRL) begin
            ctrl_run <= reg_wdata[0];
            ctl_cap  <= reg_wdata[1];
            ctl_auto <= reg_wdata[2];
            ctl_ie   <= reg_wdata[3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            comp_stage <= '0;
            comp_q     <= '0;
        end else if (reg_wr && reg_addr == A_COMP_LO) begin
            comp_stage <= reg_wdata;
        end else if (reg_wr && reg_addr == A_COMP_HI) begin
            comp_q <= {reg_wdata, comp_stage};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       shadow <= TIME_RST;
        else if (capture) shadow <= now;
    end

    generate
        for (genvar g = 0; g < ALM_FIELDS; g++) begin : g_alm
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    alm_q[g] <= '0;
                else if (reg_wr && reg_addr == A_ALARM + ADDR_W'(g))
                    alm_q[g] <= reg_wdata;
            end
            assign alm_flat[g*BW +: BW] = alm_q[g];
        end
    endgenerate

    rtc_run_ctrl u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_req (ctrl_run),
        .tick    (tick),
        .running (running)
    );

    rtc_subsec #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_sub (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en   (ctrl_run),
        .tick       (tick),
        .clear      (wr_time),
        .comp_apply (comp_apply),
        .comp       (comp_q),
        .sec_step   (sec_step)
    );

    rtc_date_counter u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_step (sec_step),
        .wr_en    (wr_time),
        .wr_idx   (reg_addr[2:0]),
        .wr_data  (reg_wdata),
        .now      (now)
    );

    rtc_alarm_unit u_alm (
        .clk          (clk),
        .rst_n        (rst_n),
        .now_fields   (now_flat[BW*ALM_FIELDS-1:0]),
        .alarm_fields (alm_flat),
        .clr          (alarm_clr),
        .flag         (alarm_flag)
    );

    assign alarm_irq = alarm_flag && ctl_ie;

    always_comb begin
        reg_rdata = '0;
        for (int f = 0; f < TIME_FIELDS; f++) begin
            if (reg_addr == ADDR_W'(f)) reg_rdata = shadow_flat[f*BW +: BW];
        end
        for (int f = 0; f < ALM_FIELDS; f++) begin
            if (reg_addr == A_ALARM + ADDR_W'(f)) reg_rdata = alm_q[f];
        end
        if (reg_addr == A_CTRL)    reg_rdata = {4'b0, ctl_ie, ctl_auto, ctl_cap, ctrl_run};
        if (reg_addr == A_STAT)    reg_rdata = {6'b0, alarm_flag, running};
        if (reg_addr == A_COMP_LO) reg_rdata = comp_q[7:0];
        if (reg_addr == A_COMP_HI) reg_rdata = comp_q[15:8];
    end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_run,
    input logic        wr_time,
    input logic        capture,
    input logic        sec_step,
    input logic        running,
    input logic        alarm_flag,
    input logic        alarm_clr,
    input logic [55:0] now_flat,
    input logic [55:0] shadow_flat
);
    // R3
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_run && !wr_time) |=> $stable(now_flat));

    // R2
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(shadow_flat));

    // R4
    run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_run |=> !running);

    // R5
    sec_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_step && !wr_time) |=> (now_flat[7:0] != $past(now_flat[7:0])));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !alarm_clr) |=> alarm_flag);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && alarm_clr) |=> !alarm_flag);
endmodule

bind rtc_calendar_core rtc_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_run    (ctrl_run),
    .wr_time     (wr_time),
    .capture     (capture),
    .sec_step    (sec_step),
    .running     (running),
    .alarm_flag  (alarm_flag),
    .alarm_clr   (alarm_clr),
    .now_flat    (now_flat),
    .shadow_flat (shadow_flat)
);

// File: tb/sim_rtc_calendar_core.sv
`timescale 1ns/1ps
module sim_rtc_calendar_core;
    localparam int TPS = 4;
    localparam int AW  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic alarm_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int ms, mmin, mh, md, mmo, my, mw, msub, m_comp;
    bit m_run, m_auto;
    logic [7:0] ctrl_v = 8'h00;

    always #4 clk = ~clk;

    rtc_calendar_core #(.TICKS_PER_SEC(TPS), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .alarm_irq(alarm_irq)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        ctrl_v = v;
        wr(5'h10, v);
        m_run  = v[0];
        m_auto = v[2];
    endtask

    task automatic m_adv_sec();
        ms++;
        if (ms == 60) begin
            ms = 0; mmin++;
            if (mmin == 60) begin
                mmin = 0; mh++;
                if (mh == 24) begin
                    mh = 0; mw = (mw + 1) % 7; md++;
                    if (md > dim(mmo, my)) begin
                        md = 1; mmo++;
                        if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
                    end
                end
            end
        end
    endtask

    task automatic m_tick();
        if (!m_run) return;
        if (msub >= TPS - 1) begin
            if (m_auto && ms == 0 && mmin == 0) msub = (m_comp > TPS - 1) ? TPS - 1 : m_comp;
            else msub = 0;
            m_adv_sec();
        end else begin
            msub++;
        end
    endtask

    task automatic run_ticks(input int k);
        @(negedge clk);
        tick = 1'b1;
        repeat (k) @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        for (int i = 0; i < k; i++) m_tick();
    endtask

    task automatic set_time(input int s, input int mi, input int h, input int d,
                            input int mo, input int y, input int w);
        set_ctrl(ctrl_v & 8'hFC);
        wr(5'h00, to_bcd(s));  wr(5'h01, to_bcd(mi)); wr(5'h02, to_bcd(h));
        wr(5'h03, to_bcd(d));  wr(5'h04, to_bcd(mo)); wr(5'h05, to_bcd(y));
        wr(5'h06, to_bcd(w));
        ms = s; mmin = mi; mh = h; md = d; mmo = mo; my = y; mw = w; msub = 0;
        set_ctrl((ctrl_v & 8'hFC) | 8'h01);
    endtask

    task automatic capture();
        wr(5'h10, ctrl_v & 8'hFD);
        wr(5'h10, ctrl_v | 8'h02);
    endtask

    task automatic read_time(output logic [55:0] t);
        logic [7:0] b;
        t = '0;
        for (int i = 0; i < 7; i++) begin
            rd(5'(i), b);
            t[i*8 +: 8] = b;
        end
    endtask

    function automatic logic [55:0] m_time();
        return {to_bcd(mw), to_bcd(my), to_bcd(mmo), to_bcd(md), to_bcd(mh), to_bcd(mmin), to_bcd(ms)};
    endfunction

    task automatic cap_check(input string req);
        logic [55:0] t;
        capture();
        read_time(t);
        chk(req, 64'(t), 64'(m_time()));
    endtask

    task automatic set_comp(input int c);
        logic [15:0] v;
        v = 16'(c);
        wr(5'h12, v[7:0]);
        wr(5'h13, v[15:8]);
        m_comp = c;
    endtask

    task automatic set_alarm(input int s, input int mi, input int h, input int d,
                             input int mo, input int y);
        wr(5'h08, to_bcd(s)); wr(5'h09, to_bcd(mi)); wr(5'h0A, to_bcd(h));
        wr(5'h0B, to_bcd(d)); wr(5'h0C, to_bcd(mo)); wr(5'h0D, to_bcd(y));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic [55:0] t0, t1;
        void'($urandom(32'd20240611));
        ms = 0; mmin = 0; mh = 0; md = 1; mmo = 1; my = 0; mw = 0; msub = 0;
        m_comp = 0; m_run = 0; m_auto = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h10, b); chk("R1 reset ctrl", 64'(b), 64'h00);
        rd(5'h11, b); chk("R1 reset status", 64'(b), 64'h00);
        rd(5'h12, b); chk("R1 reset comp lo", 64'(b), 64'h00);
        rd(5'h13, b); chk("R1 reset comp hi", 64'(b), 64'h00);
        capture();
        read_time(t0);
        chk("R1 reset time", 64'(t0), 64'h00_00_01_01_00_00_00);

        // R4 run status
        set_time(10, 20, 8, 5, 3, 21, 2);
        rd(5'h11, b); chk("R4 running low before first tick", 64'(b[0]), 64'd0);
        run_ticks(1);
        rd(5'h11, b); chk("R4 running high after tick", 64'(b[0]), 64'd1);
        run_ticks(TPS * 2 - 1);
        cap_check("R5 two seconds");

        // R2 shadow holds while counting, recapture with bit already 1 ignored
        run_ticks(TPS * 3);
        read_time(t1);
        chk("R2 shadow stable without capture", 64'(t1), 64'h02_21_03_05_08_20_12);
        wr(5'h10, ctrl_v | 8'h02);
        wr(5'h10, ctrl_v | 8'h02);
        read_time(t1);
        chk("R2 repeated bit1 no capture", 64'(t1), 64'h02_21_03_05_08_20_12);
        cap_check("R2 fresh capture");

        // R3 stopped: ticks ignored
        set_ctrl(ctrl_v & 8'hFE);
        rd(5'h11, b); chk("R4 running low after stop", 64'(b[0]), 64'd0);
        run_ticks(TPS * 5);
        cap_check("R3 no advance when stopped");
        set_ctrl(ctrl_v | 8'h01);
        run_ticks(TPS - 1);
        wr(5'h00, 8'h30); ms = 30; msub = 0;
        run_ticks(TPS - 1);
        cap_check("R3 time write clears subsecond");
        run_ticks(1);
        cap_check("R3 second after cleared subsecond");

        // R5 R6 directed rollovers
        set_time(59, 59, 23, 28, 2, 24, 6);
        run_ticks(TPS);
        cap_check("R6 leap feb 28 to 29 and weekday 6 to 0");
        set_time(59, 59, 23, 29, 2, 24, 3);
        run_ticks(TPS);
        cap_check("R6 leap feb 29 to mar 1");
        set_time(59, 59, 23, 28, 2, 23, 1);
        run_ticks(TPS);
        cap_check("R6 common feb 28 to mar 1");
        set_time(59, 59, 23, 30, 4, 50, 4);
        run_ticks(TPS);
        cap_check("R6 apr 30 to may 1");
        set_time(59, 59, 23, 31, 12, 99, 5);
        run_ticks(TPS);
        cap_check("R5 year 99 wraps to 00");
        chk("R5 model wrap", 64'(m_time()), 64'h06_00_01_01_00_00_00);

        // R7 compensation load order
        set_comp(2);
        wr(5'h12, 8'h7B);
        rd(5'h12, b); chk("R7 low byte staged only", 64'(b), 64'h02);
        wr(5'h13, 8'h01);
        rd(5'h12, b); chk("R7 low byte committed", 64'(b), 64'h7B);
        rd(5'h13, b); chk("R7 high byte committed", 64'(b), 64'h01);

        // R8 compensation
        set_comp(2);
        set_ctrl(8'h05);
        set_time(0, 0, 5, 10, 7, 22, 1);
        run_ticks(TPS + TPS - 2);
        cap_check("R8 positive shortens second");
        chk("R8 positive literal", 64'(ms), 64'd2);
        set_comp(-3);
        set_time(0, 0, 5, 10, 7, 22, 1);
        run_ticks(TPS + TPS + 2);
        cap_check("R8 negative lengthens second (not yet)");
        run_ticks(1);
        cap_check("R8 negative lengthens second");
        set_comp(100);
        set_time(0, 0, 9, 10, 7, 22, 1);
        run_ticks(TPS + 1);
        cap_check("R8 clamp to one tick");
        set_comp(2);
        set_time(0, 7, 5, 10, 7, 22, 1);
        run_ticks(TPS + TPS - 2);
        cap_check("R8 minute not zero ignores value");
        set_ctrl(8'h01);
        set_time(0, 0, 5, 10, 7, 22, 1);
        run_ticks(TPS + TPS - 2);
        cap_check("R8 auto off ignores value");

        // R9 R10 R11 alarm
        set_alarm(12, 30, 12, 15, 6, 25);
        set_time(10, 30, 12, 15, 6, 25, 0);
        run_ticks(TPS * 2);
        rd(5'h11, b); chk("R9 flag set on match", 64'(b[1]), 64'd1);
        chk("R11 irq gated off", 64'(alarm_irq), 64'd0);
        set_ctrl(ctrl_v | 8'h08);
        @(negedge clk); chk("R11 irq with enable", 64'(alarm_irq), 64'd1);
        run_ticks(TPS);
        rd(5'h11, b); chk("R9 flag sticky after match ends", 64'(b[1]), 64'd1);
        wr(5'h11, 8'h01);
        rd(5'h11, b); chk("R10 write zero keeps flag", 64'(b[1]), 64'd1);
        wr(5'h11, 8'h02);
        rd(5'h11, b); chk("R10 write one clears flag", 64'(b[1]), 64'd0);
        chk("R11 irq low after clear", 64'(alarm_irq), 64'd0);
        set_time(11, 30, 12, 15, 6, 25, 0);
        run_ticks(TPS);
        set_ctrl(ctrl_v & 8'hFE);
        rd(5'h11, b); chk("R9 flag on second match", 64'(b[1]), 64'd1);
        wr(5'h11, 8'h02);
        repeat (3) @(negedge clk);
        rd(5'h11, b); chk("R10 no reset while match persists", 64'(b[1]), 64'd0);
        set_ctrl(ctrl_v | 8'h01);
        run_ticks(TPS);
        wr(5'h00, 8'h12); ms = 12; msub = 0;
        repeat (2) @(negedge clk);
        rd(5'h11, b); chk("R10 match recurs sets flag", 64'(b[1]), 64'd1);
        wr(5'h11, 8'h02);
        set_ctrl(8'h01);

        // random calendar runs
        for (int i = 0; i < 28; i++) begin
            int s, mi, h, d, mo, y, w, sel, k;
            y = $urandom_range(99, 0); mo = $urandom_range(12, 1);
            d = $urandom_range(dim(mo, y), 1); h = $urandom_range(23, 0);
            mi = $urandom_range(59, 0); s = $urandom_range(59, 0); w = $urandom_range(6, 0);
            sel = $urandom_range(3, 0);
            if (sel == 0) begin s = 59; mi = 59; h = 23; d = dim(mo, y); end
            if (sel == 1) begin s = 0; mi = 0; end
            set_comp(int'($urandom_range(12, 0)) - 6);
            set_ctrl(($urandom_range(1, 0) != 0) ? 8'h05 : 8'h01);
            set_time(s, mi, h, d, mo, y, w);
            k = $urandom_range(TPS * 3 + 2, 1);
            run_ticks(k);
            cap_check((sel == 0) ? "R6 random day-end run" : "R5 R8 random run");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule